// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block accepts a parallel byte from a processor, parks it in a single holding register, and shifts it out on a serial line as one asynchronous character. Each character is a low start bit, 5 to 8 data bits sent least significant bit first, an optional odd or even parity bit, and a stop period of 1, 1.5 or 2 bit times. One bit time is 1, 16 or 64 pulses of an external transmit tick, so the baud rate follows whatever rate generator drives the tick input.

Framing and command fields come in as static inputs from a configuration sequencer. The processor side sees a ready flag that says the holding register can take a new byte, and an empty flag that says the whole transmitter is quiet. A pending byte moves into the shifter on the same clock that ends the previous stop period, so a stream of writes produces characters with no idle time between them. A break command pulls the line low at once, whatever the shifter is doing.

Top module: `ser_tx_core`

## Requirements
- R1: Out of reset, and whenever nothing is pending or in flight, `txd` is high, `tx_ready` is 1 and `tx_empty` is 1.
- R2: One bit time lasts a number of `tick_en` pulses chosen by `cfg_div`: code 1 gives 1, code 2 gives 16, code 3 gives 64 (code 0 behaves as code 1). Clocks without `tick_en` do not advance the line.
- R3: A character starts with one low bit, then sends `cfg_len`+5 data bits (`cfg_len` 0..3 gives 5..8) least significant first; buffer bits above the chosen length never reach the line.
- R4: With `cfg_par_en` set, one parity bit follows the data; it makes the count of ones over data plus parity even when `cfg_par_even` is 1 and odd when it is 0.
- R5: The stop period is high for 1 bit time when `cfg_stop` is 1 (or 0), 1.5 bit times when it is 2, and 2 bit times when it is 3.
- R6: With a bit time of one tick, a 1.5-bit stop setting lasts 2 ticks.
- R7: A buffered byte moves into the shifter only while `cmd_tx_en` is 1; otherwise it waits in the buffer and the line stays idle.
- R8: `tx_ready` is 1 exactly when the holding register is free; the clock after a write it reads 0 until the byte moves into the shifter. A write into a full buffer replaces the pending byte.
- R9: `tx_empty` is 1 only when the holding register is free and no character is being shifted.
- R10: A byte pending at the end of a stop period starts its start bit in the very next bit slot, with no idle gap.
- R11: While `cmd_break` is 1, `txd` is low; when it clears, the line returns to what the shifter is sending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Transmit tick, one clock wide per pulse |
| cfg_div | input | 2 | Bit time select: 1 = 1 tick, 2 = 16, 3 = 64 |
| cfg_len | input | 2 | Data length select: 0..3 = 5..8 bits |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_stop | input | 2 | Stop select: 1 = 1 bit, 2 = 1.5 bits, 3 = 2 bits |
| cmd_tx_en | input | 1 | Allow a new character to start |
| cmd_break | input | 1 | Force the line low |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| txd | output | 1 | Serial output line |
| tx_ready | output | 1 | Holding register can accept a byte |
| tx_empty | output | 1 | Holding register and shifter both idle |

## Verification
The properties take for granted that the framing inputs (`cfg_*`) stay constant whenever `tx_empty` is 0, since a change mid-character would alter the running bit count and parity. The directed scenarios only reprogram the frame while the transmitter is empty, holding the break and enable commands as the test calls for, and keep `tick_en` a single-clock pulse per tick, mostly asserted every clock so that bit slots line up with clock counts. Writes into a full buffer occur only in the back-to-back scenario, after the ready flag has been seen high.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  typedef enum logic [2:0] {
    TXS_IDLE  = 3'd0,
    TXS_START = 3'd1,
    TXS_DATA  = 3'd2,
    TXS_PAR   = 3'd3,
    TXS_STOP  = 3'd4
  } txs_e;

  localparam logic [1:0] DIV_SEL_MID  = 2'd2;
  localparam logic [1:0] DIV_SEL_HI   = 2'd3;
  localparam logic [1:0] STOP_SEL_1P5 = 2'd2;
  localparam logic [1:0] STOP_SEL_2   = 2'd3;
  localparam int unsigned MIN_BITS    = 5;

endpackage

// File: rtl/ser_tx_timer.sv
// Counts transmit ticks within the current phase and flags its last tick.
module ser_tx_timer #(
  parameter int unsigned DIV_MID = 16,
  parameter int unsigned DIV_HI  = 64,
  parameter int unsigned CNT_W   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       restart,
  input  logic       in_stop,
  input  logic [1:0] div_sel,
  input  logic [1:0] stop_sel,
  output logic       phase_done
);
  import ser_tx_pkg::*;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] bit_len, stop_len, limit_m1;

  always_comb begin
    unique case (div_sel)
      DIV_SEL_MID: bit_len = CNT_W'(DIV_MID);
      DIV_SEL_HI:  bit_len = CNT_W'(DIV_HI);
      default:     bit_len = CNT_W'(1);
    endcase
  end

  // A one-tick bit cannot be halved: 1.5 stop bits round up to two.
  always_comb begin
    unique case (stop_sel)
      STOP_SEL_1P5: stop_len = (bit_len == CNT_W'(1)) ? CNT_W'(2)
                                                     : bit_len + (bit_len >> 1);
      STOP_SEL_2:   stop_len = bit_len << 1;
      default:      stop_len = bit_len;
    endcase
  end

  assign limit_m1   = (in_stop ? stop_len : bit_len) - CNT_W'(1);
  assign phase_done = tick_en && (cnt_q == limit_m1);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)         cnt_d = '0;
    else if (phase_done) cnt_d = '0;
    else if (tick_en)    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ser_tx_hold.sv
// One-deep holding register between the processor and the shifter.
module ser_tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    full_d = (full_q && !take) || wr_en;
    data_d = wr_en ? wr_data : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      if (wr_en) data_q <= data_d;
    end
  end

  assign full = full_q;
  assign data = data_q;

endmodule

// File: rtl/ser_tx_fsm.sv
// Character sequencer: start, data, optional parity, stop.
module ser_tx_fsm #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_done,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              tx_en,
  input  logic              brk,
  input  logic [1:0]        len_sel,
  input  logic              par_en,
  input  logic              par_even,
  output logic              take,
  output logic              in_stop,
  output logic              busy,
  output logic              txd
);
  import ser_tx_pkg::*;

  txs_e              state_q, state_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              par_q, par_d;
  logic [DATA_W-1:0] len_mask;
  logic [DATA_W-1:0] masked;
  logic [IDX_W-1:0]  last_idx;
  logic              line;

  always_comb begin
    for (int i = 0; i < int'(DATA_W); i++)
      len_mask[i] = (i < (int'(MIN_BITS) + int'(len_sel)));
  end

  assign masked   = hold_data & len_mask;
  assign last_idx = IDX_W'(int'(MIN_BITS) - 1 + int'(len_sel));

  assign take = tx_en && hold_full &&
                ((state_q == TXS_IDLE) || ((state_q == TXS_STOP) && phase_done));

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    idx_d   = idx_q;
    par_d   = par_q;
    if (take) begin
      state_d = TXS_START;
      shreg_d = masked;
      idx_d   = '0;
      par_d   = par_even ? (^masked) : ~(^masked);
    end else if (phase_done) begin
      unique case (state_q)
        TXS_START: state_d = TXS_DATA;
        TXS_DATA: begin
          shreg_d = shreg_q >> 1;
          idx_d   = idx_q + IDX_W'(1);
          if (idx_q == last_idx) state_d = par_en ? TXS_PAR : TXS_STOP;
        end
        TXS_PAR:  state_d = TXS_STOP;
        TXS_STOP: state_d = TXS_IDLE;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TXS_IDLE;
      shreg_q <= '0;
      idx_q   <= '0;
      par_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      idx_q   <= idx_d;
      par_q   <= par_d;
    end
  end

  always_comb begin
    unique case (state_q)
      TXS_START: line = 1'b0;
      TXS_DATA:  line = shreg_q[0];
      TXS_PAR:   line = par_q;
      default:   line = 1'b1;
    endcase
  end

  assign txd     = line && !brk;
  assign in_stop = (state_q == TXS_STOP);
  assign busy    = (state_q != TXS_IDLE);

endmodule

// File: rtl/ser_tx_core.sv
module ser_tx_core #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DIV_MID = 16,
  parameter int unsigned DIV_HI  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [1:0]        cfg_div,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic [1:0]        cfg_stop,
  input  logic              cmd_tx_en,
  input  logic              cmd_break,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              tx_ready,
  output logic              tx_empty
);

  localparam int unsigned CNT_W = $clog2(2 * DIV_HI + 1);
  localparam int unsigned IDX_W = $clog2(DATA_W);

  logic              take;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              phase_done;
  logic              in_stop;
  logic              busy;

  ser_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (take),
    .full    (hold_full),
    .data    (hold_data)
  );

  ser_tx_timer #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI), .CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .restart    (take),
    .in_stop    (in_stop),
    .div_sel    (cfg_div),
    .stop_sel   (cfg_stop),
    .phase_done (phase_done)
  );

  ser_tx_fsm #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_done (phase_done),
    .hold_full  (hold_full),
    .hold_data  (hold_data),
    .tx_en      (cmd_tx_en),
    .brk        (cmd_break),
    .len_sel    (cfg_len),
    .par_en     (cfg_par_en),
    .par_even   (cfg_par_even),
    .take       (take),
    .in_stop    (in_stop),
    .busy       (busy),
    .txd        (txd)
  );

  assign tx_ready = !hold_full;
  assign tx_empty = !hold_full && !busy;

endmodule

// File: rtl/ser_tx_core_chk.sv
module ser_tx_core_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_tx_en,
  input logic cmd_break,
  input logic wr_en,
  input logic txd,
  input logic tx_ready,
  input logic tx_empty
);

  // R11: break forces the line low
  a_r11_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_break |-> !txd);

  // R1: an empty transmitter holds the line high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !cmd_break) |-> txd);

  // R8: a written byte makes the buffer busy on the next clock
  a_r8_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tx_ready);

  // R9: empty implies the buffer is free
  a_r9_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> tx_ready);

  // R7: with transmit disabled and no write, an empty block stays empty
  a_r7_stay_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_tx_en && !wr_en && tx_empty) |=> tx_empty);

  // R7: with transmit disabled, a pending byte is not consumed
  a_r7_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_tx_en && !tx_ready) |=> !tx_ready);

endmodule

bind ser_tx_core ser_tx_core_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_tx_en (cmd_tx_en),
  .cmd_break (cmd_break),
  .wr_en     (wr_en),
  .txd       (txd),
  .tx_ready  (tx_ready),
  .tx_empty  (tx_empty)
);

// File: tb/ser_tx_core_bench.sv
module ser_tx_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk;
  logic       rst_n;
  logic       tick_en;
  logic [1:0] cfg_div, cfg_len, cfg_stop;
  logic       cfg_par_en, cfg_par_even;
  logic       cmd_tx_en, cmd_break;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       txd, tx_ready, tx_empty;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  ser_tx_core u_ser_tx_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .cfg_div(cfg_div), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .cfg_stop(cfg_stop),
    .cmd_tx_en(cmd_tx_en), .cmd_break(cmd_break),
    .wr_en(wr_en), .wr_data(wr_data),
    .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int bit_ticks(input logic [1:0] d);
    return (d == 2'd2) ? 16 : (d == 2'd3) ? 64 : 1;
  endfunction

  function automatic int stop_ticks(input logic [1:0] d, input logic [1:0] s);
    int b = bit_ticks(d);
    if (s == 2'd3) return 2 * b;
    if (s == 2'd2) return (b == 1) ? 2 : b + b / 2;
    return b;
  endfunction

  // Compare txd at each negedge from the current one over a whole frame.
  task automatic watch_frame(input logic [7:0] d, input string req);
    int b   = bit_ticks(cfg_div);
    int nb  = 5 + int'(cfg_len);
    int bad = 0;
    int first_at = -1, first_act = 0, first_exp = 0;
    int pos = 0;
    logic ones = 1'b0;
    logic [0:0] e;
    for (int ph = 0; ph < nb + 3; ph++) begin
      int dur;
      if (ph == 0) begin e = 1'b0; dur = b; end
      else if (ph <= nb) begin e = d[ph-1]; ones ^= d[ph-1]; dur = b; end
      else if (ph == nb + 1) begin
        if (!cfg_par_en) continue;
        e = cfg_par_even ? ones : ~ones; dur = b;
      end else begin e = 1'b1; dur = stop_ticks(cfg_div, cfg_stop); end
      for (int k = 0; k < dur; k++) begin
        if (txd !== e[0] && bad == 0) begin
          first_at = pos; first_act = int'(txd); first_exp = int'(e[0]);
        end
        if (txd !== e[0]) bad++;
        pos++;
        @(negedge clk);
      end
    end
    n_checks++;
    if (bad != 0) begin
      n_fails++;
      $display("FAIL %s frame 0x%02h: sample %0d actual %0d expected %0d",
               req, d, first_at, first_act, first_exp);
    end
  endtask

  // Write at a negedge; returns at the negedge where the start bit shows.
  task automatic send(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_frame(input logic [1:0] d, input logic [1:0] l,
                           input logic pe, input logic pv, input logic [1:0] s);
    cfg_div = d; cfg_len = l; cfg_par_en = pe; cfg_par_even = pv; cfg_stop = s;
  endtask

  task automatic t_reset;
    check("R1", "txd after reset", int'(txd), 1);
    check("R1", "tx_ready after reset", int'(tx_ready), 1);
    check("R1", "tx_empty after reset", int'(tx_empty), 1);
  endtask

  task automatic t_8n1_fast;   // R2 R3 R5: 8 data bits, one tick per bit
    set_frame(2'd1, 2'd3, 1'b0, 1'b0, 2'd1);
    send(8'hA5);
    check("R8", "tx_ready after load", int'(tx_ready), 1);
    watch_frame(8'hA5, "R3");
    check("R9", "tx_empty after frame", int'(tx_empty), 1);
  endtask

  task automatic t_7e1_div16;  // R2 R3 R4: bit 7 must not appear
    set_frame(2'd2, 2'd2, 1'b1, 1'b1, 2'd1);
    send(8'hB5);
    check("R9", "tx_empty during frame", int'(tx_empty), 0);
    watch_frame(8'h35, "R4");
  endtask

  task automatic t_5o15_div16; // R4 R5: odd parity, 1.5 stop at 16
    set_frame(2'd2, 2'd0, 1'b1, 1'b0, 2'd2);
    send(8'hF3);
    watch_frame(8'h13, "R5");
    check("R5", "tx_empty after 1.5 stop", int'(tx_empty), 1);
  endtask

  task automatic t_6n2_div64;  // R2 R5: 64 ticks per bit, 2 stop
    set_frame(2'd3, 2'd1, 1'b0, 1'b0, 2'd3);
    send(8'h2D);
    watch_frame(8'h2D, "R2");
  endtask

  task automatic t_fast_15;    // R6: 1.5 stop at one tick rounds to 2
    set_frame(2'd1, 2'd3, 1'b1, 1'b1, 2'd2);
    send(8'h0F);
    watch_frame(8'h0F, "R6");
    check("R6", "tx_empty after rounded stop", int'(tx_empty), 1);
  endtask

  task automatic t_back_to_back; // R8 R10
    set_frame(2'd1, 2'd3, 1'b1, 1'b0, 2'd1);
    send(8'h81);
    fork
      watch_frame(8'h81, "R10");
      begin
        wr_en = 1'b1; wr_data = 8'h11;
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h7E;  // replaces pending byte
        @(negedge clk);
        wr_en = 1'b0;
        check("R8", "tx_ready with byte pending", int'(tx_ready), 0);
      end
    join
    watch_frame(8'h7E, "R10");
    check("R10", "tx_empty after second frame", int'(tx_empty), 1);
  endtask

  task automatic t_disabled;   // R7
    set_frame(2'd1, 2'd3, 1'b0, 1'b0, 2'd1);
    cmd_tx_en = 1'b0;
    send(8'h00);
    repeat (20) @(negedge clk);
    check("R7", "txd while disabled", int'(txd), 1);
    check("R7", "tx_ready while disabled", int'(tx_ready), 0);
    check("R9", "tx_empty while disabled", int'(tx_empty), 0);
    cmd_tx_en = 1'b1;
    @(negedge clk);
    watch_frame(8'h00, "R7");
  endtask

  task automatic t_break;      // R11
    cmd_break = 1'b1;
    @(negedge clk);
    check("R11", "txd under break at idle", int'(txd), 0);
    cmd_break = 1'b0;
    @(negedge clk);
    check("R11", "txd after break at idle", int'(txd), 1);
    set_frame(2'd2, 2'd3, 1'b0, 1'b0, 2'd1);
    send(8'hFF);
    repeat (40) @(negedge clk);  // in data bits, all ones
    check("R11", "txd on a one data bit", int'(txd), 1);
    cmd_break = 1'b1;
    @(negedge clk);
    check("R11", "txd under break mid frame", int'(txd), 0);
    cmd_break = 1'b0;
    @(negedge clk);
    check("R11", "txd after break mid frame", int'(txd), 1);
    while (!tx_empty) @(negedge clk);
    check("R1", "txd idle after frame", int'(txd), 1);
  endtask

  task automatic t_tick_gate;  // R2: no tick, no progress
    set_frame(2'd1, 2'd3, 1'b0, 1'b0, 2'd1);
    tick_en = 1'b0;
    send(8'h5A);
    repeat (30) @(negedge clk);
    check("R2", "start held without ticks", int'(txd), 0);
    tick_en = 1'b1;
    watch_frame(8'h5A, "R2");
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b1; wr_en = 1'b0; wr_data = '0;
    cmd_tx_en = 1'b1; cmd_break = 1'b0;
    set_frame(2'd1, 2'd3, 1'b0, 1'b0, 2'd1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_8n1_fast();
    t_7e1_div16();
    t_5o15_div16();
    t_6n2_div64();
    t_fast_15();
    t_back_to_back();
    t_disabled();
    t_break();
    t_tick_gate();
    repeat (3) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule